// File: doc/BRIEF.md
# Byte-Wide Configuration Register Slave on a Two-Wire Serial Bus

This block gives a host on a standard I2C bus read and write access to a bank of byte-wide configuration registers. It listens for a 7-bit device address taken from seven strap pins. It also accepts the all-zero broadcast address for writes, so one frame can configure every chip on a shared bus. A write frame sends the device address with the write flag, then a register index, then one or more data bytes. A read frame first sends the index in a short write frame. A repeated START follows, then the device address with the read flag, and the block returns register contents MSB first. Reads never change the stored value.

The block has two identical clock/data pin pairs. A select input chooses which pair is listened to and driven, so a board can reach the chip over either of two routes. The data pins are only ever pulled low: the block drives an output enable and leaves the high level to the bus pull-up. The block samples the bus with its own system clock through synchronizers. It never holds the clock line low.

Top module: `i2c_cfg_slave`

## Requirements
- R1: While reset is held, both data output enables are low and every register reads as 0x00.
- R2: A first byte whose upper seven bits (sent MSB first) equal `dev_addr` is acknowledged, whatever its bit 0. Bit 0 is the direction flag: 0 = write, 1 = read.
- R3: A first byte that matches neither `dev_addr` nor the broadcast address is not acknowledged, and the rest of that frame changes no register.
- R4: In a write frame the byte after the address is the register index. Each later byte is stored at the current index. The index byte and every data byte are acknowledged.
- R5: The index advances by one after each data byte, written or read. It uses the low log2(REG_COUNT) bits of the index byte and wraps from the last register to register 0.
- R6: The broadcast address 0x00 with the write flag is acknowledged and writes registers like a matched address.
- R7: The broadcast address with the read flag is not acknowledged.
- R8: After a repeated START, the device address with the read flag returns the register at the current index, MSB first. A master ACK continues with the next register. A master NACK ends the transfer. Register contents are unchanged by reads.
- R9: A STOP at any point returns the block to idle, and a partly received data byte is discarded. A START or repeated START at any point restarts address reception.
- R10: Only the pin pair picked by `port_sel` (0 = pair A, 1 = pair B) is listened to. The other pair is never driven, and traffic on it has no effect.
- R11: The block changes its data output enable only while the selected clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Strapped device address |
| port_sel | input | 1 | Pin pair select, 0 = pair A, 1 = pair B |
| scl_a_i | input | 1 | Clock line of pair A |
| sda_a_i | input | 1 | Data line level of pair A |
| sda_a_oe | output | 1 | Pull data line of pair A low when 1 |
| scl_b_i | input | 1 | Clock line of pair B |
| sda_b_i | input | 1 | Data line level of pair B |
| sda_b_oe | output | 1 | Pull data line of pair B low when 1 |
| cfg_regs | output | REG_COUNT*8 | All register contents, register n in bits 8n+7..8n |

## Verification
The hardest cases to reach are frames that end in the middle of a byte: a STOP after four data bits, or a repeated START after three. The design must discard the partial shift register and keep the register index. The bench reaches these with bit-level master tasks that can stop after any number of bits. After each such frame it sends a full frame and compares the register image with its own model. A second hard case is a read that runs across the last register. The stimulus first writes three bytes that wrap to register 0, then reads them back with ACK, ACK, NACK and checks that the image is unchanged.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

   typedef enum logic [3:0] {
      LS_IDLE,
      LS_DEV,
      LS_ACK_DEV,
      LS_IDX,
      LS_ACK_IDX,
      LS_WDATA,
      LS_ACK_WDATA,
      LS_RDATA,
      LS_RD_HANDSHAKE,
      LS_IGNORE
   } link_state_t;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda;
   } bus_evt_t;

   localparam logic [6:0] BROADCAST_ADDR = 7'h00;

endpackage

// File: rtl/i2c_port_mux.sv
module i2c_port_mux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic port_sel,
   input  logic scl_a_i,
   input  logic sda_a_i,
   input  logic scl_b_i,
   input  logic sda_b_i,
   input  logic drive_low,
   output logic sda_a_oe,
   output logic sda_b_oe,
   output logic scl_s,
   output logic sda_s
);

   logic [1:0] raw;
   logic [1:0] synced;

   assign raw[0] = port_sel ? scl_b_i : scl_a_i;
   assign raw[1] = port_sel ? sda_b_i : sda_a_i;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
         end
         assign synced[g] = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign scl_s    = synced[0];
   assign sda_s    = synced[1];
   assign sda_a_oe = drive_low & ~port_sel;
   assign sda_b_oe = drive_low &  port_sel;

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
   import i2c_cfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.scl_rise = ~scl_q & scl_s;
      evt.scl_fall = scl_q & ~scl_s;
      evt.start    = scl_q & scl_s & sda_q & ~sda_s;
      evt.stop     = scl_q & scl_s & ~sda_q & sda_s;
      evt.sda      = sda_s;
   end

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
   import i2c_cfg_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt,
   input  logic [6:0]        dev_addr,
   input  logic [7:0]        rd_data,
   output logic [IDX_W-1:0]  idx,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [7:0]        wr_data,
   output logic              wr_en,
   output logic              drive_low,
   output link_state_t       state
);

   logic [7:0] shreg;
   logic [7:0] txreg;
   logic [2:0] bitcnt;
   logic       byte_full;
   logic       is_read;
   logic       host_nack;
   logic       addr_hit;

   always_comb begin
      addr_hit = (shreg[7:1] == dev_addr) ||
                 ((shreg[7:1] == BROADCAST_ADDR) && !shreg[0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= LS_IDLE;
         shreg     <= '0;
         txreg     <= '0;
         bitcnt    <= '0;
         byte_full <= 1'b0;
         is_read   <= 1'b0;
         host_nack <= 1'b0;
         idx       <= '0;
         wr_idx    <= '0;
         wr_data   <= '0;
         wr_en     <= 1'b0;
         drive_low <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (evt.stop) begin
            state     <= LS_IDLE;
            drive_low <= 1'b0;
            byte_full <= 1'b0;
         end else if (evt.start) begin
            state     <= LS_DEV;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            drive_low <= 1'b0;
         end else if (evt.scl_rise) begin
            case (state)
               LS_DEV, LS_IDX, LS_WDATA: begin
                  shreg  <= {shreg[6:0], evt.sda};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) byte_full <= 1'b1;
               end
               LS_RD_HANDSHAKE: host_nack <= evt.sda;
               default: ;
            endcase
         end else if (evt.scl_fall) begin
            case (state)
               LS_DEV: begin
                  if (byte_full) begin
                     byte_full <= 1'b0;
                     if (addr_hit) begin
                        drive_low <= 1'b1;
                        is_read   <= shreg[0];
                        state     <= LS_ACK_DEV;
                     end else begin
                        state <= LS_IGNORE;
                     end
                  end
               end
               LS_ACK_DEV: begin
                  if (is_read) begin
                     txreg     <= rd_data;
                     drive_low <= ~rd_data[7];
                     bitcnt    <= '0;
                     state     <= LS_RDATA;
                  end else begin
                     drive_low <= 1'b0;
                     state     <= LS_IDX;
                  end
               end
               LS_IDX: begin
                  if (byte_full) begin
                     byte_full <= 1'b0;
                     idx       <= shreg[IDX_W-1:0];
                     drive_low <= 1'b1;
                     state     <= LS_ACK_IDX;
                  end
               end
               LS_ACK_IDX, LS_ACK_WDATA: begin
                  drive_low <= 1'b0;
                  state     <= LS_WDATA;
               end
               LS_WDATA: begin
                  if (byte_full) begin
                     byte_full <= 1'b0;
                     wr_en     <= 1'b1;
                     wr_idx    <= idx;
                     wr_data   <= shreg;
                     idx       <= idx + IDX_W'(1);
                     drive_low <= 1'b1;
                     state     <= LS_ACK_WDATA;
                  end
               end
               LS_RDATA: begin
                  if (bitcnt == 3'd7) begin
                     drive_low <= 1'b0;
                     idx       <= idx + IDX_W'(1);
                     state     <= LS_RD_HANDSHAKE;
                  end else begin
                     txreg     <= {txreg[6:0], 1'b0};
                     drive_low <= ~txreg[6];
                     bitcnt    <= bitcnt + 3'd1;
                  end
               end
               LS_RD_HANDSHAKE: begin
                  if (host_nack) begin
                     state <= LS_IGNORE;
                  end else begin
                     txreg     <= rd_data;
                     drive_low <= ~rd_data[7];
                     bitcnt    <= '0;
                     state     <= LS_RDATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
   parameter int         REG_COUNT = 16,
   parameter logic [7:0] RESET_VAL = 8'h00,
   localparam int        IDX_W     = $clog2(REG_COUNT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [7:0]             wr_data,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic [7:0]             rd_data,
   output logic [REG_COUNT*8-1:0] flat
);

   logic [7:0] regs [REG_COUNT];

   generate
      for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           regs[r] <= RESET_VAL;
            else if (wr_en && wr_idx == IDX_W'(r)) regs[r] <= wr_data;
         end
         assign flat[r*8 +: 8] = regs[r];
      end
   endgenerate

   assign rd_data = regs[rd_idx];

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
   import i2c_cfg_pkg::*;
#(
   parameter int REG_COUNT   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [6:0]             dev_addr,
   input  logic                   port_sel,
   input  logic                   scl_a_i,
   input  logic                   sda_a_i,
   output logic                   sda_a_oe,
   input  logic                   scl_b_i,
   input  logic                   sda_b_i,
   output logic                   sda_b_oe,
   output logic [REG_COUNT*8-1:0] cfg_regs
);

   localparam int IDX_W = $clog2(REG_COUNT);

   generate
      if (REG_COUNT < 2 || REG_COUNT > 256 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
         $error("REG_COUNT must be a power of two between 2 and 256");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              scl_s, sda_s;
   logic              drive_low;
   bus_evt_t          bus_evt;
   link_state_t       link_state;
   logic [IDX_W-1:0]  cur_idx;
   logic [IDX_W-1:0]  reg_wr_idx;
   logic [7:0]        reg_wr_data;
   logic              reg_wr_en;
   logic [7:0]        reg_rd_data;

   i2c_port_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_sel  (port_sel),
      .scl_a_i   (scl_a_i),
      .sda_a_i   (sda_a_i),
      .scl_b_i   (scl_b_i),
      .sda_b_i   (sda_b_i),
      .drive_low (drive_low),
      .sda_a_oe  (sda_a_oe),
      .sda_b_oe  (sda_b_oe),
      .scl_s     (scl_s),
      .sda_s     (sda_s)
   );

   i2c_bus_cond u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .evt   (bus_evt)
   );

   i2c_link_fsm #(.IDX_W(IDX_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (bus_evt),
      .dev_addr  (dev_addr),
      .rd_data   (reg_rd_data),
      .idx       (cur_idx),
      .wr_idx    (reg_wr_idx),
      .wr_data   (reg_wr_data),
      .wr_en     (reg_wr_en),
      .drive_low (drive_low),
      .state     (link_state)
   );

   i2c_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_idx  (reg_wr_idx),
      .wr_data (reg_wr_data),
      .rd_idx  (cur_idx),
      .rd_data (reg_rd_data),
      .flat    (cfg_regs)
   );

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
   import i2c_cfg_pkg::*;
#(
   parameter int REG_COUNT = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   port_sel,
   input  logic                   scl_a_i,
   input  logic                   scl_b_i,
   input  logic                   sda_a_oe,
   input  logic                   sda_b_oe,
   input  link_state_t            state,
   input  bus_evt_t               evt,
   input  logic                   wr_en,
   input  logic [REG_COUNT*8-1:0] cfg_regs
);

   logic scl_sel, oe_sel, oe_any;

   always_comb begin
      scl_sel = port_sel ? scl_b_i : scl_a_i;
      oe_sel  = port_sel ? sda_b_oe : sda_a_oe;
      oe_any  = sda_a_oe | sda_b_oe;
   end

   // R11: output enable only moves while the selected clock is low
   assert_oe_steady_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_sel && $past(scl_sel) && $stable(port_sel)) |-> $stable(oe_sel));

   // R2: pulling the line low only happens in acknowledge or read-data phases
   assert_drive_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_any |-> (state == LS_ACK_DEV || state == LS_ACK_IDX ||
                  state == LS_ACK_WDATA || state == LS_RDATA));

   // R4: registers change only after a write strobe from the protocol engine
   assert_reg_change_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_regs != $past(cfg_regs)) |-> $past(wr_en));

   // R9: a STOP returns to idle with the line released
   assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> (state == LS_IDLE && !oe_any));

   // R9: a START restarts address reception
   assert_start_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.start && !evt.stop) |=> (state == LS_DEV));

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.REG_COUNT(REG_COUNT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .port_sel (port_sel),
   .scl_a_i  (scl_a_i),
   .scl_b_i  (scl_b_i),
   .sda_a_oe (sda_a_oe),
   .sda_b_oe (sda_b_oe),
   .state    (link_state),
   .evt      (bus_evt),
   .wr_en    (reg_wr_en),
   .cfg_regs (cfg_regs)
);

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb;

   localparam int NREG = 16;
   localparam logic [6:0] MY_ADDR = 7'h2A;

   typedef struct packed {
      logic       port;
      logic [6:0] addr;
      logic [7:0] idx;
      logic [7:0] data;
      logic       ack;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 7'h2A, 8'h03, 8'hA5, 1'b1},
      '{1'b1, 7'h2A, 8'h04, 8'h3C, 1'b1},
      '{1'b0, 7'h00, 8'h05, 8'h77, 1'b1},
      '{1'b0, 7'h2B, 8'h06, 8'h11, 1'b0},
      '{1'b1, 7'h55, 8'h07, 8'h22, 1'b0},
      '{1'b0, 7'h2A, 8'h13, 8'h99, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic port_sel = 1'b0;
   logic scl_a = 1'b1, scl_b = 1'b1;
   logic m_sda_a = 1'b1, m_sda_b = 1'b1;
   logic sda_a_oe, sda_b_oe;
   logic [NREG*8-1:0] cfg_regs;
   logic sda_a_line, sda_b_line;

   assign sda_a_line = m_sda_a & ~sda_a_oe;
   assign sda_b_line = m_sda_b & ~sda_b_oe;

   always #5 clk = ~clk;

   i2c_cfg_slave #(.REG_COUNT(NREG)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_addr (MY_ADDR),
      .port_sel (port_sel),
      .scl_a_i  (scl_a),
      .sda_a_i  (sda_a_line),
      .sda_a_oe (sda_a_oe),
      .scl_b_i  (scl_b),
      .sda_b_i  (sda_b_line),
      .sda_b_oe (sda_b_oe),
      .cfg_regs (cfg_regs)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic cur_port = 1'b0;
   logic [7:0] model [NREG];
   int od_viol = 0;
   int unsel_viol = 0;
   logic pscl_a = 1'b1, pscl_b = 1'b1, poe_a = 1'b0, poe_b = 1'b0;

   // independent monitors for R10 and R11
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_a && pscl_a && sda_a_oe != poe_a) od_viol++;
         if (scl_b && pscl_b && sda_b_oe != poe_b) od_viol++;
         if (port_sel ? sda_a_oe : sda_b_oe) unsel_viol++;
      end
      pscl_a = scl_a; pscl_b = scl_b; poe_a = sda_a_oe; poe_b = sda_b_oe;
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NREG*8-1:0] model_flat();
      logic [NREG*8-1:0] f;
      for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
      return f;
   endfunction

   task automatic hp();
      repeat (8) @(negedge clk);
   endtask

   task automatic set_scl(input logic v);
      if (cur_port) scl_b = v; else scl_a = v;
   endtask

   task automatic set_sda(input logic v);
      if (cur_port) m_sda_b = v; else m_sda_a = v;
   endtask

   function automatic logic line_sda();
      return cur_port ? sda_b_line : sda_a_line;
   endfunction

   task automatic bus_start();
      set_sda(1'b1); set_scl(1'b1); hp();
      set_sda(1'b0); hp();
      set_scl(1'b0); hp();
   endtask

   task automatic bus_rstart();
      set_sda(1'b1); hp();
      set_scl(1'b1); hp();
      set_sda(1'b0); hp();
      set_scl(1'b0); hp();
   endtask

   task automatic bus_stop();
      set_sda(1'b0); hp();
      set_scl(1'b1); hp();
      set_sda(1'b1); hp();
   endtask

   task automatic put_bit(input logic b);
      set_sda(b); hp();
      set_scl(1'b1); hp();
      set_scl(1'b0); hp();
   endtask

   task automatic get_bit(output logic b);
      set_sda(1'b1); hp();
      set_scl(1'b1); hp();
      b = line_sda();
      set_scl(1'b0); hp();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 0; i < 8; i++) begin
         get_bit(b);
         d = {d[6:0], b};
      end
      put_bit(~give_ack);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic ak;
      logic [7:0] rd;
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 oe_a", {127'd0, sda_a_oe}, 128'd0);
      chk("R1 oe_b", {127'd0, sda_b_oe}, 128'd0);
      chk("R1 regs", cfg_regs, 128'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // table: R2 R3 R6 R10 write frames on both pairs
      for (int v = 0; v < NVEC; v++) begin
         port_sel = VEC[v].port;
         cur_port = VEC[v].port;
         hp();
         bus_start();
         send_byte({VEC[v].addr, 1'b0}, ak);
         chk("R2/R3/R6 address ack", {127'd0, ak}, {127'd0, VEC[v].ack});
         send_byte(VEC[v].idx, ak);
         send_byte(VEC[v].data, ak);
         bus_stop();
         if (VEC[v].ack) model[VEC[v].idx[3:0]] = VEC[v].data;
         hp();
         chk("R4/R3 register image", cfg_regs, model_flat());
      end

      // R5: multi-byte write wrapping past the last register
      port_sel = 1'b0; cur_port = 1'b0; hp();
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak);
      send_byte(8'h0E, ak);
      chk("R4 index ack", {127'd0, ak}, 128'd1);
      send_byte(8'h11, ak);
      send_byte(8'h22, ak);
      send_byte(8'h33, ak);
      chk("R4 data ack", {127'd0, ak}, 128'd1);
      bus_stop();
      model[14] = 8'h11; model[15] = 8'h22; model[0] = 8'h33;
      hp();
      chk("R5 wrap write", cfg_regs, model_flat());

      // R8: indexed read with repeated START, ack/ack/nack
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak);
      send_byte(8'h0E, ak);
      bus_rstart();
      send_byte({MY_ADDR, 1'b1}, ak);
      chk("R2 read address ack", {127'd0, ak}, 128'd1);
      recv_byte(1'b1, rd);
      chk("R8 read byte 0", {120'd0, rd}, {120'd0, 8'h11});
      recv_byte(1'b1, rd);
      chk("R8 read byte 1", {120'd0, rd}, {120'd0, 8'h22});
      recv_byte(1'b0, rd);
      chk("R5 R8 read wrapped byte", {120'd0, rd}, {120'd0, 8'h33});
      bus_stop();
      hp();
      chk("R8 non-destructive", cfg_regs, model_flat());

      // R7: broadcast read is refused
      bus_start();
      send_byte({7'h00, 1'b1}, ak);
      chk("R7 broadcast read ack", {127'd0, ak}, 128'd0);
      bus_stop();
      hp();

      // R9: STOP mid data byte discards the partial byte
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak);
      send_byte(8'h05, ak);
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      bus_stop();
      hp();
      chk("R9 stop mid byte", cfg_regs, model_flat());

      // R9: repeated START mid data byte restarts address phase
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak);
      send_byte(8'h08, ak);
      for (int i = 0; i < 3; i++) put_bit(1'b1);
      bus_rstart();
      send_byte({MY_ADDR, 1'b0}, ak);
      chk("R9 address after restart", {127'd0, ak}, 128'd1);
      send_byte(8'h09, ak);
      send_byte(8'h5A, ak);
      bus_stop();
      model[9] = 8'h5A;
      hp();
      chk("R9 restart write", cfg_regs, model_flat());

      // R10: traffic on the unselected pair is ignored
      port_sel = 1'b0; cur_port = 1'b1; hp();
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak);
      chk("R10 unselected ack", {127'd0, ak}, 128'd0);
      send_byte(8'h01, ak);
      send_byte(8'hEE, ak);
      bus_stop();
      hp();
      chk("R10 unselected write", cfg_regs, model_flat());

      // R10: read back through pair B once selected
      port_sel = 1'b1; hp();
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak);
      send_byte(8'h03, ak);
      bus_rstart();
      send_byte({MY_ADDR, 1'b1}, ak);
      recv_byte(1'b0, rd);
      bus_stop();
      chk("R10 read via pair B", {120'd0, rd}, {120'd0, 8'h99});
      hp();

      chk("R11 enable moved with clock high", od_viol, 128'd0);
      chk("R10 unselected pair driven", unsel_viol, 128'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule